// File: doc/BRIEF.md
# XY Pixel Address Stepper

This block keeps a packed two-dimensional pixel pointer in a 16-bit register. The horizontal coordinate sits in the low bits and the vertical coordinate above it. A one-hot pitch code chooses where the split falls. Each time the host makes a pixel access, the block registers a linear memory address built from the pointer as it stood before the access. It then moves the pointer according to a 4-bit step code.

The step code combines three horizontal actions with three vertical ones. The horizontal actions are increment, decrement and clear. The vertical actions are increment, decrement and clear. When the horizontal coordinate steps on its own, the step acts on the whole register, so a carry or borrow can spill into the vertical field. When it steps together with a vertical move of one line, it wraps inside its own field. Four page bits are placed above the 16-bit pointer, and a size mask trims the address to the memory that is fitted. The memory itself lies outside this block.

Top module: `xy_addr_unit`

## Requirements
- R1: After reset, `xy_q` is 0, `mem_addr` is 0 and `addr_vld` is 0. The split is the one given by pitch code 0x10, so the horizontal field is 6 bits wide.
- R2: A `pitch_wr` with `pitch_code` equal to `1 << k` (k = 0..7) sets the horizontal field width to k+2 bits. A vertical step of one line then adds or subtracts `1 << (k+2)`.
- R3: A `pitch_wr` with a `pitch_code` that does not have exactly one bit set leaves the field split unchanged.
- R4: On the clock edge that samples `acc_stb`, `mem_addr` takes the value (({page_bits, 16'h0000}) | xy_q before the step) & size_mask. `addr_vld` is high for exactly the cycle after each strobe cycle. Page bits 3:0 map to address bits 19:16.
- R5: The step code is split into a horizontal action in bits 1:0 (0 keep, 1 +1, 2 -1, 3 clear) and a vertical action in bits 3:2 (0 keep, 1 +1, 2 -1, 3 clear). With vertical action 0, code 0 leaves the pointer unchanged. Codes 1 and 2 add or subtract 1 across the whole register, so the carry or borrow reaches the vertical field. Code 3 clears only the horizontal field.
- R6: With vertical action +1 or -1, the horizontal action is applied modulo 2^width inside its field, and the vertical field then moves by one line.
- R7: With vertical action "clear", only the horizontal result is kept. For +1 and -1 this result is the low field of the whole-register step. Code 15 clears the entire register.
- R8: If `xy_wr` is high in the same cycle as `acc_stb`, the pointer loads `xy_wdata` and no step is applied. The address is still formed from the old pointer.
- R9: When neither `acc_stb` nor `xy_wr` is high, the pointer does not change. This holds even if the pitch or the page bits change.
- R10: All pointer arithmetic wraps modulo 2^16. For example, 0xFFFF+1 gives 0, and 0-1 gives 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pitch_wr | input | 1 | Load a new pitch code |
| pitch_code | input | 8 | One-hot field split code |
| page_bits | input | 4 | Upper address bits placed at 19:16 |
| size_mask | input | 20 | Mask of valid memory address bits |
| xy_wr | input | 1 | Host load of the pointer |
| xy_wdata | input | 16 | Value loaded by `xy_wr` |
| acc_stb | input | 1 | Pixel access strobe |
| adj_code | input | 4 | Post-access step code |
| mem_addr | output | 20 | Registered pixel memory address |
| addr_vld | output | 1 | `mem_addr` was formed on the previous edge |
| xy_q | output | 16 | Current pointer |

## Verification
The bench applies all sixteen step codes to several starting pointers. The all-zero and all-ones pointers expose wraparound. A horizontal field that is all ones separates a whole-register carry from a wrap inside the field. A pointer with only vertical bits set separates a borrow into the vertical field from a field-confined decrement. Each of the eight pitch codes is shown to be decoded by a one-line vertical step from zero and by a field-wrapping step, and malformed pitch codes are shown to leave the line step unchanged. Address tests use page bits and a narrowing mask together, so that an address formed after the step or without the mask gives a different value.

// File: rtl/xy_pkg.sv
package xy_pkg;
  localparam int XY_W       = 16;
  localparam int PAGE_W     = 4;
  localparam int ADDR_W     = XY_W + PAGE_W;
  localparam int PITCH_W    = 8;
  localparam int SHIFT_W    = 4;
  localparam int SHIFT_BASE = 2;
  localparam int CODE_W     = 4;

  localparam logic [PITCH_W-1:0] PITCH_RST = PITCH_W'(8'h10);
  localparam logic [SHIFT_W-1:0] SHIFT_RST = SHIFT_W'(6);

  typedef enum logic [1:0] {X_KEEP, X_INC, X_DEC, X_CLR} x_act_e;
  typedef enum logic [1:0] {Y_KEEP, Y_INC, Y_DEC, Y_CLR} y_act_e;

  // ones in the horizontal field
  function automatic logic [XY_W-1:0] field_mask(input logic [SHIFT_W-1:0] s);
    return (XY_W'(1) << s) - XY_W'(1);
  endfunction

  // pointer after one access
  function automatic logic [XY_W-1:0] next_xy(input logic [XY_W-1:0]    xy,
                                              input logic [CODE_W-1:0]  code,
                                              input logic [SHIFT_W-1:0] s);
    logic [XY_W-1:0] m, ystep, whole, confined, res;
    x_act_e xa;
    y_act_e ya;
    m     = field_mask(s);
    ystep = XY_W'(1) << s;
    xa    = x_act_e'(code[1:0]);
    ya    = y_act_e'(code[3:2]);
    case (xa)
      X_INC:   whole = xy + XY_W'(1);
      X_DEC:   whole = xy - XY_W'(1);
      X_CLR:   whole = xy & ~m;
      default: whole = xy;
    endcase
    // the horizontal step kept inside its own field
    confined = (xy & ~m) | (whole & m);
    case (ya)
      Y_INC:   res = confined + ystep;
      Y_DEC:   res = confined - ystep;
      Y_CLR:   res = whole & m;
      default: res = whole;
    endcase
    return res;
  endfunction

  function automatic logic [ADDR_W-1:0] form_addr(input logic [XY_W-1:0]   xy,
                                                  input logic [PAGE_W-1:0] page,
                                                  input logic [ADDR_W-1:0] msk);
    return ((ADDR_W'(page) << XY_W) | ADDR_W'(xy)) & msk;
  endfunction
endpackage

// File: rtl/xy_pitch_reg.sv
module xy_pitch_reg
  import xy_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [PITCH_W-1:0] code,
  output logic [SHIFT_W-1:0] shift_q,
  output logic               code_ok
);
  logic [PITCH_W-1:0] hit;
  logic [SHIFT_W-1:0] dec_shift;

  for (genvar k = 0; k < PITCH_W; k++) begin : g_hit
    assign hit[k] = (code == (PITCH_W'(1) << k));
  end

  always_comb begin
    dec_shift = shift_q;
    for (int k = 0; k < PITCH_W; k++) begin
      if (hit[k]) dec_shift = SHIFT_W'(k + SHIFT_BASE);
    end
  end

  assign code_ok = |hit;

  always_ff @(posedge clk) begin
    if (!rst_n)              shift_q <= SHIFT_RST;
    else if (wr && code_ok)  shift_q <= dec_shift;
  end
endmodule

// File: rtl/xy_step.sv
module xy_step
  import xy_pkg::*;
(
  input  logic [XY_W-1:0]    xy,
  input  logic [CODE_W-1:0]  code,
  input  logic [SHIFT_W-1:0] shift,
  output logic [XY_W-1:0]    xy_next
);
  assign xy_next = next_xy(xy, code, shift);
endmodule

// File: rtl/xy_addr_reg.sv
module xy_addr_reg
  import xy_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic [XY_W-1:0]   xy,
  input  logic [PAGE_W-1:0] page,
  input  logic [ADDR_W-1:0] msk,
  output logic [ADDR_W-1:0] addr,
  output logic              vld
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr <= '0;
      vld  <= 1'b0;
    end else begin
      vld <= stb;
      if (stb) addr <= form_addr(xy, page, msk);
    end
  end
endmodule

// File: rtl/xy_addr_unit.sv
module xy_addr_unit
  import xy_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pitch_wr,
  input  logic [PITCH_W-1:0] pitch_code,
  input  logic [PAGE_W-1:0]  page_bits,
  input  logic [ADDR_W-1:0]  size_mask,
  input  logic               xy_wr,
  input  logic [XY_W-1:0]    xy_wdata,
  input  logic               acc_stb,
  input  logic [CODE_W-1:0]  adj_code,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic               addr_vld,
  output logic [XY_W-1:0]    xy_q
);
  logic [SHIFT_W-1:0] shift_w;
  logic               pitch_ok_w;
  logic [XY_W-1:0]    stepped_w;
  logic               step_en_w;

  xy_pitch_reg i_pitch (
    .clk(clk), .rst_n(rst_n), .wr(pitch_wr), .code(pitch_code),
    .shift_q(shift_w), .code_ok(pitch_ok_w)
  );

  xy_step i_step (
    .xy(xy_q), .code(adj_code), .shift(shift_w), .xy_next(stepped_w)
  );

  xy_addr_reg i_addr (
    .clk(clk), .rst_n(rst_n), .stb(acc_stb), .xy(xy_q), .page(page_bits),
    .msk(size_mask), .addr(mem_addr), .vld(addr_vld)
  );

  // host load wins over the step
  assign step_en_w = acc_stb && !xy_wr;

  always_ff @(posedge clk) begin
    if (!rst_n)         xy_q <= '0;
    else if (xy_wr)     xy_q <= xy_wdata;
    else if (step_en_w) xy_q <= stepped_w;
  end
endmodule

// File: rtl/xy_addr_unit_chk.sv
module xy_addr_unit_chk
  import xy_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               pitch_wr,
  input logic [PITCH_W-1:0] pitch_code,
  input logic [PAGE_W-1:0]  page_bits,
  input logic [ADDR_W-1:0]  size_mask,
  input logic               xy_wr,
  input logic [XY_W-1:0]    xy_wdata,
  input logic               acc_stb,
  input logic [CODE_W-1:0]  adj_code,
  input logic [ADDR_W-1:0]  mem_addr,
  input logic               addr_vld,
  input logic [XY_W-1:0]    xy_q,
  input logic [SHIFT_W-1:0] shift_w
);
  // R4
  addr_pre_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_stb |=> mem_addr == (((ADDR_W'($past(page_bits)) << XY_W) |
                              ADDR_W'($past(xy_q))) & $past(size_mask)));
  // R4
  vld_follows_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_stb |=> addr_vld);
  // R4
  vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_stb |=> !addr_vld);
  // R8
  host_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xy_wr |=> xy_q == $past(xy_wdata));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_stb && !xy_wr) |=> $stable(xy_q));
  // R5
  code_zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && !xy_wr && adj_code == 4'h0) |=> $stable(xy_q));
  // R7
  full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && !xy_wr && adj_code == 4'hF) |=> xy_q == '0);
  // R3
  bad_pitch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pitch_wr && $countones(pitch_code) != 1) |=> $stable(shift_w));
  // R2
  shift_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (shift_w >= SHIFT_W'(SHIFT_BASE) &&
              shift_w <= SHIFT_W'(SHIFT_BASE + PITCH_W - 1)));
endmodule

bind xy_addr_unit xy_addr_unit_chk i_xy_chk (
  .clk(clk), .rst_n(rst_n), .pitch_wr(pitch_wr), .pitch_code(pitch_code),
  .page_bits(page_bits), .size_mask(size_mask), .xy_wr(xy_wr),
  .xy_wdata(xy_wdata), .acc_stb(acc_stb), .adj_code(adj_code),
  .mem_addr(mem_addr), .addr_vld(addr_vld), .xy_q(xy_q), .shift_w(shift_w)
);

// File: tb/test_xy_addr_unit.sv
`timescale 1ns/1ps
module test_xy_addr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pitch_wr = 1'b0;
  logic [7:0]  pitch_code = 8'h00;
  logic [3:0]  page_bits = 4'h0;
  logic [19:0] size_mask = 20'hFFFFF;
  logic        xy_wr = 1'b0;
  logic [15:0] xy_wdata = 16'h0;
  logic        acc_stb = 1'b0;
  logic [3:0]  adj_code = 4'h0;
  logic [19:0] mem_addr;
  logic        addr_vld;
  logic [15:0] xy_q;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  xy_addr_unit i_xy_addr_unit (
    .clk(clk), .rst_n(rst_n), .pitch_wr(pitch_wr), .pitch_code(pitch_code),
    .page_bits(page_bits), .size_mask(size_mask), .xy_wr(xy_wr),
    .xy_wdata(xy_wdata), .acc_stb(acc_stb), .adj_code(adj_code),
    .mem_addr(mem_addr), .addr_vld(addr_vld), .xy_q(xy_q)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // field-wise restatement of the stepping rules
  function automatic logic [15:0] ref_xy(input logic [15:0] xy, input logic [3:0] code, input int s);
    logic [15:0] m, x, y, xn, yn;
    m = 16'((32'd1 << s) - 1);
    x = xy & m;
    y = xy >> s;
    case (code[1:0])
      2'd1: xn = (x + 16'd1) & m;
      2'd2: xn = (x - 16'd1) & m;
      2'd3: xn = 16'd0;
      default: xn = x;
    endcase
    case (code[3:2])
      2'd0: begin
        case (code[1:0])
          2'd1: return xy + 16'd1;
          2'd2: return xy - 16'd1;
          2'd3: return 16'(y << s);
          default: return xy;
        endcase
      end
      2'd1: begin yn = y + 16'd1; return 16'(yn << s) | xn; end
      2'd2: begin yn = y - 16'd1; return 16'(yn << s) | xn; end
      default: return xn;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] code);
    case (code[3:2])
      2'd0: return "R5";
      2'd3: return "R7";
      default: return "R6";
    endcase
  endfunction

  task automatic set_pitch(input logic [7:0] p);
    @(negedge clk); pitch_wr = 1'b1; pitch_code = p;
    @(negedge clk); pitch_wr = 1'b0;
  endtask

  task automatic load_xy(input logic [15:0] v);
    @(negedge clk); xy_wr = 1'b1; xy_wdata = v;
    @(negedge clk); xy_wr = 1'b0;
  endtask

  task automatic access(input logic [3:0] code);
    @(negedge clk); acc_stb = 1'b1; adj_code = code;
    @(negedge clk); acc_stb = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 xy", 32'(xy_q), 32'h0);
    check("R1 addr", 32'(mem_addr), 32'h0);
    check("R1 vld", 32'(addr_vld), 32'h0);
    access(4'h4);
    check("R1 default split", 32'(xy_q), 32'h40);
  endtask

  task automatic t_address;
    page_bits = 4'h5; size_mask = 20'h3FFFF;
    load_xy(16'hABCD);
    access(4'h1);
    check("R4 addr pre-step", 32'(mem_addr), 32'h1ABCD);
    check("R4 vld", 32'(addr_vld), 32'h1);
    check("R5 step after addr", 32'(xy_q), 32'hABCE);
    @(negedge clk);
    check("R4 vld one cycle", 32'(addr_vld), 32'h0);
    size_mask = 20'hFFFFF; page_bits = 4'hA;
    access(4'h0);
    check("R4 page bits", 32'(mem_addr), 32'hAABCE);
    page_bits = 4'h0;
  endtask

  task automatic t_sweep(input int k);
    logic [15:0] seeds [5] = '{16'h0000, 16'h003F, 16'hFFFF, 16'h1234, 16'h7FC0};
    set_pitch(8'(1 << k));
    foreach (seeds[i]) begin
      for (int c = 0; c < 16; c++) begin
        load_xy(seeds[i]);
        access(4'(c));
        check(req_of(4'(c)), 32'(xy_q), 32'(ref_xy(seeds[i], 4'(c), k + 2)));
      end
    end
  endtask

  task automatic t_pitch;
    for (int k = 0; k < 8; k++) begin
      set_pitch(8'(1 << k));
      load_xy(16'h0000);
      access(4'h4);
      check("R2 line step", 32'(xy_q), 32'(1 << (k + 2)));
      load_xy(16'((1 << (k + 2)) - 1));
      access(4'h5);
      check("R2 field wrap", 32'(xy_q), 32'(1 << (k + 2)));
    end
  endtask

  task automatic t_bad_pitch;
    set_pitch(8'h10);
    set_pitch(8'h03);
    set_pitch(8'h00);
    set_pitch(8'hFF);
    load_xy(16'h0000);
    access(4'h4);
    check("R3 bad pitch ignored", 32'(xy_q), 32'h40);
  endtask

  task automatic t_priority;
    load_xy(16'h0050);
    @(negedge clk);
    xy_wr = 1'b1; xy_wdata = 16'h1234; acc_stb = 1'b1; adj_code = 4'h1;
    @(negedge clk);
    xy_wr = 1'b0; acc_stb = 1'b0;
    check("R8 load wins", 32'(xy_q), 32'h1234);
    check("R8 addr from old", 32'(mem_addr), 32'h00050);
  endtask

  task automatic t_idle;
    load_xy(16'h4321);
    @(negedge clk); pitch_wr = 1'b1; pitch_code = 8'h01; page_bits = 4'h3; adj_code = 4'hF;
    @(negedge clk); pitch_wr = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 idle hold", 32'(xy_q), 32'h4321);
    check("R9 no vld", 32'(addr_vld), 32'h0);
    page_bits = 4'h0;
  endtask

  task automatic t_wrap;
    set_pitch(8'h10);
    load_xy(16'hFFFF); access(4'h1);
    check("R10 inc wrap", 32'(xy_q), 32'h0);
    load_xy(16'h0000); access(4'h2);
    check("R10 dec wrap", 32'(xy_q), 32'hFFFF);
    load_xy(16'hFFC5); access(4'h4);
    check("R10 line wrap", 32'(xy_q), 32'h0005);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_address();
    t_sweep(4);
    t_sweep(0);
    t_pitch();
    t_bad_pitch();
    t_priority();
    t_idle();
    t_wrap();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule